// File: doc/BRIEF.md
# Framebuffer Burst Fetch Controller

This block reads a framebuffer out of memory and pushes it, one 32-bit word at a time, into a downstream pixel FIFO. Reads are issued as fixed-length bursts over a request/grant read port. A burst request is raised only when the FIFO has enough room. Room is judged against a fill threshold that leaves space for two bursts plus a small margin. The fetch pointer starts at a programmed base address and advances by one burst per burst. A word counter tracks progress through the frame, and the pointer returns to the base once the frame has been read.

The frame length in words is worked out inside the block from the column count, the row count and a bits-per-pixel code. It is latched together with the base address by a single load strobe. Fetching runs only while the enable input is high and a base has been loaded. A synchronous DMA reset input abandons any burst in progress and restarts the frame from the base. Clearing the enable lets the burst in flight finish and then stops further requests.

Top module: `fbf_burst_fetch`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it rises, `mem_req` and `fifo_wr_en` are 0.
- R2: No request is raised until `cfg_base_load` has been pulsed at least once since reset and `cfg_enable` is high. Either condition alone gives no request.
- R3: `mem_len` always reads the burst length minus one (7 for the default 8-word burst). Every granted burst writes exactly 8 words to the FIFO, and each word equals the `mem_rdata` word returned with `mem_rvalid`.
- R4: The first burst after a load or DMA reset reads at the base address. Each later burst in the same frame reads at the previous burst address plus 32 bytes.
- R5: The frame length in words is cols × rows × (1 << bpp_code) / 32. `cfg_bpp_code` 0..5 selects 1, 2, 4, 8, 16 or 32 bits per pixel, and codes above 5 act as 5.
- R6: A burst that brings the word count to or past the frame length is the last of the frame. The next burst reads at the base address, so each frame spans ceil(frame/8) × 8 words, or 8 words for a zero-length frame.
- R7: A request is raised only when `fifo_level` is below the threshold FIFO_DEPTH − (2 × 8 + 3), which is 45 for a depth of 64, and the free space FIFO_DEPTH − `fifo_level` is at least 8.
- R8: Once raised, `mem_req` stays high with a stable `mem_addr` until a cycle with `mem_gnt` high.
- R9: Dropping `cfg_enable` while a request is pending lets that burst be granted and deliver all 8 words. No further request follows.
- R10: A `soft_rst` cycle drops `mem_req` and clears the word count. Words still returned by memory are not written to the FIFO. The next burst reads at the base address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous DMA reset: abandons the burst and rewinds to the base |
| cfg_enable | input | 1 | Fetch enable |
| cfg_base_load | input | 1 | Strobe that latches base address and frame geometry |
| cfg_base_addr | input | 32 | Frame base byte address |
| cfg_cols | input | 12 | Pixels per line |
| cfg_rows | input | 12 | Lines per frame |
| cfg_bpp_code | input | 3 | log2 of bits per pixel (0..5) |
| fifo_level | input | 7 | Current FIFO fill level in words |
| fifo_wr_en | output | 1 | FIFO write strobe |
| fifo_wr_data | output | 32 | FIFO write word |
| mem_req | output | 1 | Burst read request |
| mem_addr | output | 32 | Burst start byte address |
| mem_len | output | 3 | Burst length minus one |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read word valid |
| mem_rdata | input | 32 | Read word |

## Verification
The fetch path is exercised over a table of geometries. Frame lengths of 2, 3, 8, 15 and 32 words separate a frame that is an exact burst multiple from one rounded up to the next burst, and also show when the wrap happens. Every FIFO word and burst address is compared against an address-as-data memory. A wrong step, a wrong wrap point or a wrong size formula therefore shows up at once. FIFO levels of 44, 45 and 60 place the threshold decision on either side of its boundary. Directed runs cover load without enable, enable without load, enable dropped during a pending request, and DMA reset in mid-burst with memory still streaming.

// File: rtl/fbf_pkg.sv
package fbf_pkg;

   typedef enum logic [1:0] {
      FS_IDLE = 2'd0,
      FS_REQ  = 2'd1,
      FS_DATA = 2'd2
   } fetch_state_e;

   localparam int unsigned BPP_CODE_MAX = 5;
   localparam int unsigned WORD_BITS_LOG2 = 5;

endpackage

// File: rtl/fbf_frame_size.sv
module fbf_frame_size #(
   parameter int unsigned DIM_W = 12,
   parameter int unsigned FRM_W = 2 * DIM_W
) (
   input  logic [DIM_W-1:0] cols,
   input  logic [DIM_W-1:0] rows,
   input  logic [2:0]       bpp_code,
   output logic [FRM_W-1:0] words
);
   import fbf_pkg::*;

   localparam int unsigned PROD_W = 2 * DIM_W;
   localparam int unsigned BITS_W = PROD_W + BPP_CODE_MAX;

   if (FRM_W < PROD_W) begin : g_bad_frm_w
      $error("fbf_frame_size: FRM_W must hold cols*rows");
   end

   logic [PROD_W-1:0] pix_count;
   logic [2:0]        code_c;
   logic [BITS_W-1:0] bit_count;
   logic [BITS_W-1:0] word_count;

   always_comb begin
      pix_count  = PROD_W'(cols) * PROD_W'(rows);
      code_c     = (bpp_code > 3'(BPP_CODE_MAX)) ? 3'(BPP_CODE_MAX) : bpp_code;
      bit_count  = BITS_W'(pix_count) << code_c;
      word_count = bit_count >> WORD_BITS_LOG2;
      words      = FRM_W'(word_count);
   end

endmodule

// File: rtl/fbf_room_gate.sv
module fbf_room_gate #(
   parameter int unsigned FIFO_DEPTH  = 64,
   parameter int unsigned BURST_LEN   = 8,
   parameter int unsigned FIFO_THRESH = FIFO_DEPTH - (2 * BURST_LEN + 3),
   parameter int unsigned LVL_W       = $clog2(FIFO_DEPTH + 1)
) (
   input  logic [LVL_W-1:0] fifo_level,
   output logic             issue_ok
);

   if (FIFO_THRESH == 0 || FIFO_THRESH > FIFO_DEPTH) begin : g_bad_thresh
      $error("fbf_room_gate: threshold must lie in 1..FIFO_DEPTH");
   end
   if (BURST_LEN > FIFO_DEPTH) begin : g_bad_depth
      $error("fbf_room_gate: FIFO must hold at least one burst");
   end

   logic below_thresh;
   assign below_thresh = fifo_level < LVL_W'(FIFO_THRESH);

   if (FIFO_THRESH + BURST_LEN <= FIFO_DEPTH) begin : g_thresh_only
      // level below threshold already leaves a full burst of space
      assign issue_ok = below_thresh;
   end else begin : g_free_check
      logic room_ok;
      assign room_ok  = ({1'b0, fifo_level} <= (LVL_W + 1)'(FIFO_DEPTH - BURST_LEN));
      assign issue_ok = below_thresh & room_ok;
   end

endmodule

// File: rtl/fbf_addr_walk.sv
module fbf_addr_walk #(
   parameter int unsigned ADDR_W     = 32,
   parameter int unsigned FRM_W      = 24,
   parameter int unsigned BURST_LEN  = 8,
   parameter int unsigned STEP_BYTES = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              base_load,
   input  logic [ADDR_W-1:0] base_in,
   input  logic [FRM_W-1:0]  frame_in,
   input  logic              burst_done,
   output logic [ADDR_W-1:0] cur_addr,
   output logic              armed
);

   localparam int unsigned CNT_W = FRM_W + 1;

   logic [ADDR_W-1:0] base_q;
   logic [FRM_W-1:0]  frame_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nxt;
   logic              frame_end;

   assign cnt_nxt   = cnt_q + CNT_W'(BURST_LEN);
   assign frame_end = cnt_nxt >= {1'b0, frame_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_q   <= '0;
         frame_q  <= '0;
         cnt_q    <= '0;
         cur_addr <= '0;
         armed    <= 1'b0;
      end else if (soft_rst) begin
         cnt_q    <= '0;
         cur_addr <= base_q;
      end else if (base_load) begin
         base_q   <= base_in;
         frame_q  <= frame_in;
         cnt_q    <= '0;
         cur_addr <= base_in;
         armed    <= 1'b1;
      end else if (burst_done) begin
         if (frame_end) begin
            cnt_q    <= '0;
            cur_addr <= base_q;
         end else begin
            cnt_q    <= cnt_nxt;
            cur_addr <= cur_addr + ADDR_W'(STEP_BYTES);
         end
      end
   end

   // R6: the running count never sits at or past the frame end
   a_r6_count_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0) || (cnt_q < {1'b0, frame_q}));

   // R10: a DMA reset rewinds the pointer to the loaded base
   a_r10_rewind: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cur_addr == base_q));

endmodule

// File: rtl/fbf_burst_fetch.sv
module fbf_burst_fetch #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned BURST_LEN   = 8,
   parameter int unsigned FIFO_DEPTH  = 64,
   parameter int unsigned FIFO_THRESH = FIFO_DEPTH - (2 * BURST_LEN + 3),
   parameter int unsigned DIM_W       = 12,
   parameter int unsigned FRM_W       = 2 * DIM_W
) (
   input  logic                               clk,
   input  logic                               rst_n,
   input  logic                               soft_rst,
   input  logic                               cfg_enable,
   input  logic                               cfg_base_load,
   input  logic [ADDR_W-1:0]                  cfg_base_addr,
   input  logic [DIM_W-1:0]                   cfg_cols,
   input  logic [DIM_W-1:0]                   cfg_rows,
   input  logic [2:0]                         cfg_bpp_code,
   input  logic [$clog2(FIFO_DEPTH+1)-1:0]    fifo_level,
   output logic                               fifo_wr_en,
   output logic [DATA_W-1:0]                  fifo_wr_data,
   output logic                               mem_req,
   output logic [ADDR_W-1:0]                  mem_addr,
   output logic [$clog2(BURST_LEN)-1:0]       mem_len,
   input  logic                               mem_gnt,
   input  logic                               mem_rvalid,
   input  logic [DATA_W-1:0]                  mem_rdata
);
   import fbf_pkg::*;

   localparam int unsigned LVL_W      = $clog2(FIFO_DEPTH + 1);
   localparam int unsigned LEN_W      = $clog2(BURST_LEN);
   localparam int unsigned BLEN_M1    = BURST_LEN - 1;
   localparam int unsigned STEP_BYTES = BURST_LEN * (DATA_W / 8);

   if (BURST_LEN < 2 || (BURST_LEN & (BURST_LEN - 1)) != 0) begin : g_bad_burst
      $error("fbf_burst_fetch: BURST_LEN must be a power of two, at least 2");
   end
   if (DATA_W % 8 != 0) begin : g_bad_data_w
      $error("fbf_burst_fetch: DATA_W must be whole bytes");
   end

   fetch_state_e      state_q;
   logic [LEN_W-1:0]  beat_q;
   logic              issue_ok;
   logic              armed;
   logic              burst_done;
   logic [FRM_W-1:0]  frame_words;
   logic [ADDR_W-1:0] cur_addr;

   fbf_frame_size #(
      .DIM_W (DIM_W),
      .FRM_W (FRM_W)
   ) u_size (
      .cols     (cfg_cols),
      .rows     (cfg_rows),
      .bpp_code (cfg_bpp_code),
      .words    (frame_words)
   );

   fbf_room_gate #(
      .FIFO_DEPTH  (FIFO_DEPTH),
      .BURST_LEN   (BURST_LEN),
      .FIFO_THRESH (FIFO_THRESH),
      .LVL_W       (LVL_W)
   ) u_gate (
      .fifo_level (fifo_level),
      .issue_ok   (issue_ok)
   );

   fbf_addr_walk #(
      .ADDR_W     (ADDR_W),
      .FRM_W      (FRM_W),
      .BURST_LEN  (BURST_LEN),
      .STEP_BYTES (STEP_BYTES)
   ) u_walk (
      .clk        (clk),
      .rst_n      (rst_n),
      .soft_rst   (soft_rst),
      .base_load  (cfg_base_load),
      .base_in    (cfg_base_addr),
      .frame_in   (frame_words),
      .burst_done (burst_done),
      .cur_addr   (cur_addr),
      .armed      (armed)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= FS_IDLE;
         beat_q  <= '0;
      end else if (soft_rst) begin
         state_q <= FS_IDLE;
         beat_q  <= '0;
      end else begin
         case (state_q)
            FS_IDLE: begin
               if (cfg_enable && armed && issue_ok) state_q <= FS_REQ;
            end
            FS_REQ: begin
               if (mem_gnt) begin
                  state_q <= FS_DATA;
                  beat_q  <= LEN_W'(BLEN_M1);
               end
            end
            FS_DATA: begin
               if (mem_rvalid) begin
                  if (beat_q == '0) state_q <= FS_IDLE;
                  else              beat_q  <= beat_q - 1'b1;
               end
            end
            default: state_q <= FS_IDLE;
         endcase
      end
   end

   assign burst_done   = (state_q == FS_DATA) && mem_rvalid && (beat_q == '0);
   assign mem_req      = (state_q == FS_REQ);
   assign mem_addr     = cur_addr;
   assign mem_len      = LEN_W'(BLEN_M1);
   assign fifo_wr_en   = (state_q == FS_DATA) && mem_rvalid;
   assign fifo_wr_data = mem_rdata;

   // R8: a pending request is held until granted
   a_r8_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !soft_rst) |=> mem_req);

   // R8: the address does not move under a pending request
   a_r8_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt && !soft_rst && !cfg_base_load) |=> $stable(mem_addr));

   // R7: a new request only follows an open room gate
   a_r7_issue_gate: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(issue_ok));

   // R2: a new request needs enable and a loaded base
   a_r2_armed_enabled: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> ($past(cfg_enable) && $past(armed)));

   // R10: DMA reset leaves no request and no write behind
   a_r10_soft_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!mem_req && !fifo_wr_en));

endmodule

// File: tb/fbf_burst_fetch_tb.sv
`timescale 1ns/1ps
module fbf_burst_fetch_tb;

   typedef struct packed {
      logic [11:0] cols;
      logic [11:0] rows;
      logic [2:0]  bpp;
      logic [31:0] base;
      logic [6:0]  level;
      logic        fetch;
   } vec_t;

   localparam int NVEC = 8;
   localparam vec_t VEC [NVEC] = '{
      '{cols:12'd8,  rows:12'd4, bpp:3'd3, base:32'h1000, level:7'd0,  fetch:1'b1},
      '{cols:12'd16, rows:12'd4, bpp:3'd4, base:32'h2000, level:7'd10, fetch:1'b1},
      '{cols:12'd32, rows:12'd2, bpp:3'd0, base:32'h3000, level:7'd0,  fetch:1'b1},
      '{cols:12'd4,  rows:12'd4, bpp:3'd5, base:32'h4000, level:7'd44, fetch:1'b1},
      '{cols:12'd10, rows:12'd3, bpp:3'd4, base:32'h5000, level:7'd20, fetch:1'b1},
      '{cols:12'd8,  rows:12'd8, bpp:3'd3, base:32'h6000, level:7'd45, fetch:1'b0},
      '{cols:12'd8,  rows:12'd8, bpp:3'd3, base:32'h7000, level:7'd60, fetch:1'b0},
      '{cols:12'd24, rows:12'd2, bpp:3'd1, base:32'h8000, level:7'd0,  fetch:1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        soft_rst = 1'b0;
   logic        cfg_enable = 1'b0;
   logic        cfg_base_load = 1'b0;
   logic [31:0] cfg_base_addr = '0;
   logic [11:0] cfg_cols = '0;
   logic [11:0] cfg_rows = '0;
   logic [2:0]  cfg_bpp_code = '0;
   logic [6:0]  fifo_level = '0;
   logic        fifo_wr_en;
   logic [31:0] fifo_wr_data;
   logic        mem_req;
   logic [31:0] mem_addr;
   logic [2:0]  mem_len;
   logic        mem_gnt;
   logic        mem_rvalid;
   logic [31:0] mem_rdata;

   always #2 clk = ~clk;

   fbf_burst_fetch u_dut (
      .clk           (clk),
      .rst_n         (rst_n),
      .soft_rst      (soft_rst),
      .cfg_enable    (cfg_enable),
      .cfg_base_load (cfg_base_load),
      .cfg_base_addr (cfg_base_addr),
      .cfg_cols      (cfg_cols),
      .cfg_rows      (cfg_rows),
      .cfg_bpp_code  (cfg_bpp_code),
      .fifo_level    (fifo_level),
      .fifo_wr_en    (fifo_wr_en),
      .fifo_wr_data  (fifo_wr_data),
      .mem_req       (mem_req),
      .mem_addr      (mem_addr),
      .mem_len       (mem_len),
      .mem_gnt       (mem_gnt),
      .mem_rvalid    (mem_rvalid),
      .mem_rdata     (mem_rdata)
   );

   // memory stub: grant after a short wait, return address-as-data with one gap
   int          st_mode;
   int          st_wait;
   int          st_beat;
   logic        st_gap;
   logic [31:0] st_addr;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_mode <= 0; st_wait <= 0; st_beat <= 0; st_gap <= 1'b0;
         st_addr <= '0; mem_gnt <= 1'b0; mem_rvalid <= 1'b0; mem_rdata <= '0;
      end else begin
         mem_gnt    <= 1'b0;
         mem_rvalid <= 1'b0;
         if (st_mode == 0) begin
            if (mem_req && !mem_gnt) begin
               if (st_wait == 2) begin
                  mem_gnt <= 1'b1; st_addr <= mem_addr; st_mode <= 1;
                  st_wait <= 0; st_beat <= 0; st_gap <= 1'b0;
               end else st_wait <= st_wait + 1;
            end else st_wait <= 0;
         end else begin
            if (st_beat == 8) st_mode <= 0;
            else if (st_beat == 3 && !st_gap) st_gap <= 1'b1;
            else begin
               mem_rvalid <= 1'b1;
               mem_rdata  <= st_addr + 32'(4 * st_beat);
               st_beat    <= st_beat + 1;
            end
         end
      end
   end

   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 1'b0;
   logic        mon_on = 1'b0;
   logic [31:0] mon_base = '0;
   int          mon_f8 = 8;
   int          k_word = 0;
   int          k_burst = 0;
   int          wr_total = 0;
   int          g_total = 0;
   int          req_cycles = 0;
   logic [31:0] last_gaddr = '0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (mem_req) req_cycles++;
      if (fifo_wr_en) begin
         if (mon_on) chk(fifo_wr_data == mon_base + 32'(4 * (k_word % mon_f8)),
                         "R3/R5 fifo word", fifo_wr_data, mon_base + 32'(4 * (k_word % mon_f8)));
         k_word++;
         wr_total++;
      end
      if (mem_req && mem_gnt) begin
         last_gaddr = mem_addr;
         if (mon_on) begin
            chk(mem_addr == mon_base + 32'(4 * ((k_burst * 8) % mon_f8)),
                "R4 R6 burst address", mem_addr, mon_base + 32'(4 * ((k_burst * 8) % mon_f8)));
            chk(mem_len == 3'd7, "R3 burst length field", 32'(mem_len), 32'd7);
         end
         k_burst++;
         g_total++;
      end
   end

   task automatic step(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic load_cfg(input vec_t v);
      int fw;
      fw = (int'(v.cols) * int'(v.rows) * (1 << v.bpp)) / 32;
      mon_base = v.base;
      mon_f8   = (fw == 0) ? 8 : ((fw + 7) / 8) * 8;
      soft_rst = 1'b1; step(1); soft_rst = 1'b0;
      cfg_cols = v.cols; cfg_rows = v.rows; cfg_bpp_code = v.bpp;
      cfg_base_addr = v.base; fifo_level = v.level;
      cfg_base_load = 1'b1; step(1); cfg_base_load = 1'b0;
      k_word = 0; k_burst = 0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=0x0 expected=0x1");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      int g0, w0, r0;
      #1;
      chk(mem_req == 1'b0, "R1 req in reset", 32'(mem_req), 0);
      chk(fifo_wr_en == 1'b0, "R1 write in reset", 32'(fifo_wr_en), 0);
      step(3);
      rst_n = 1'b1;
      step(1);
      chk(mem_req == 1'b0, "R1 req after reset", 32'(mem_req), 0);
      chk(fifo_wr_en == 1'b0, "R1 write after reset", 32'(fifo_wr_en), 0);
      chk(mem_len == 3'd7, "R3 length field", 32'(mem_len), 32'd7);

      // R2: enable without a loaded base
      cfg_enable = 1'b1; r0 = req_cycles;
      step(40);
      chk(req_cycles == r0, "R2 enable without load", 32'(req_cycles - r0), 0);
      // R2: load without enable
      cfg_enable = 1'b0;
      load_cfg(VEC[0]);
      r0 = req_cycles;
      step(40);
      chk(req_cycles == r0, "R2 load without enable", 32'(req_cycles - r0), 0);

      // table walk: R4 R5 R6 R7
      mon_on = 1'b1;
      for (int i = 0; i < NVEC; i++) begin
         load_cfg(VEC[i]);
         g0 = g_total; w0 = wr_total;
         cfg_enable = 1'b1;
         step(300);
         cfg_enable = 1'b0;
         step(60);
         if (VEC[i].fetch) begin
            chk((g_total - g0) >= 5, "R7 fetch below threshold", 32'(g_total - g0), 5);
            chk((wr_total - w0) == 8 * (g_total - g0), "R3 words per burst",
                32'(wr_total - w0), 32'(8 * (g_total - g0)));
         end else begin
            chk(g_total == g0, "R7 gate closed", 32'(g_total - g0), 0);
         end
      end

      // R9: drop enable under a pending request
      load_cfg(VEC[1]);
      cfg_enable = 1'b1;
      do step(1); while (!mem_req);
      cfg_enable = 1'b0;
      g0 = g_total; w0 = wr_total;
      step(80);
      chk(g_total - g0 == 1, "R9 one burst after disable", 32'(g_total - g0), 1);
      chk(wr_total - w0 == 8, "R9 burst completes", 32'(wr_total - w0), 8);
      chk(mem_req == 1'b0, "R9 no further request", 32'(mem_req), 0);

      // R10: DMA reset in mid-burst
      cfg_enable = 1'b1;
      w0 = wr_total;
      do step(1); while (wr_total < w0 + 11);
      soft_rst = 1'b1; step(1); soft_rst = 1'b0;
      k_word = 0; k_burst = 0;
      chk(mem_req == 1'b0, "R10 request dropped", 32'(mem_req), 0);
      g0 = g_total; w0 = wr_total;
      do step(1); while (g_total == g0);
      chk(wr_total == w0, "R10 stray words ignored", 32'(wr_total - w0), 0);
      chk(last_gaddr == mon_base, "R10 restart at base", last_gaddr, mon_base);
      step(100);
      cfg_enable = 1'b0;
      step(60);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule